// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns one starting word address into the addresses of a four-beat burst. A burst begins when either of two active-low address strobes is low on a rising clock edge. One strobe comes from the processor and the other from the cache controller. On that edge the block registers the address and the ordering selection. From then on, a 2-bit beat counter moves forward only on edges where the active-low advance input is low.

The output address is the registered upper address bits joined to two low bits. The order that was latched at the load decides those low bits. Linear order adds the beat count to the starting offset, modulo four. Interleaved order XORs the beat count into the starting offset. The beat count and a burst-active flag are also brought out, so that a neighbouring data path can follow the burst position.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0, `beat_out` is 0 and `burst_active` is 0.
- R2: If either `strobe_cpu_n` or `strobe_ctl_n` is low on a rising edge, then after that edge `addr_out` equals the sampled `addr_in`, `beat_out` is 0 and `burst_active` is 1.
- R3: While a burst is active and no strobe is low, `beat_out` goes up by one on each edge where `advance_n` is low. It holds its value on edges where `advance_n` is high.
- R4: With `order_sel` = 0 latched at the load (linear order), `addr_out[1:0]` equals (start offset + `beat_out`) mod 4.
- R5: With `order_sel` = 1 latched at the load (interleaved order), `addr_out[1:0]` equals (start offset XOR `beat_out`).
- R6: `addr_out[ADDR_W-1:2]` stays fixed from the load until the next load.
- R7: After beat 3, an advance wraps `beat_out` to 0, and the sequence keeps repeating for as long as `advance_n` stays low.
- R8: A strobe on the same edge as an asserted advance performs a load. The beat becomes 0 at the new address, and the advance is ignored.
- R9: A change of `order_sel` has no effect on the ordering until the next load.
- R10: Before the first load, `advance_n` low has no effect: `beat_out` stays 0 and `burst_active` stays 0.
- R11: Both strobes low on the same edge perform a single load, exactly as one strobe would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | Starting word address, sampled on load |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Cache-controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; sampled on load |
| addr_out | output | ADDR_W | Current burst address |
| beat_out | output | BEAT_W | Current beat number within the burst |
| burst_active | output | 1 | A burst has been loaded since reset |

## Verification
Two functions can land on the same edge: a load through either strobe, and a counter advance. The bench holds `advance_n` low through the middle of a burst and drops a strobe with a new address on that same edge. It then expects the new address at beat 0, not the old sequence one step on. A second collision puts both strobes low on one edge, and the result must match a single-strobe load. The same edge-level sampling also covers an `order_sel` flip in the middle of a burst, which must leave the latched order in force.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_load_ctrl.sv
module bseq_load_ctrl (
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic advance_n,
  input  logic active,
  output logic load,
  output logic step
);
  // Either strobe loads; a load masks the advance on the same edge.
  always_comb begin
    load = ~strobe_cpu_n | ~strobe_ctl_n;
    step = ~load & active & ~advance_n;
  end
endmodule

// File: rtl/bseq_beat_counter.sv
module bseq_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else if (step) cnt <= cnt + BEAT_W'(1);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt));
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> cnt == BEAT_W'($past(cnt) + 1));
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == '0);
endmodule

// File: rtl/bseq_addr_capture.sv
module bseq_addr_capture #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2,
  localparam int UP_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_in,
  output logic [UP_W-1:0]   upper_q,
  output logic [BEAT_W-1:0] start_q,
  output logic              order_q,
  output logic              active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q  <= '0;
      start_q  <= '0;
      order_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (load) begin
      upper_q  <= addr_in[ADDR_W-1:BEAT_W];
      start_q  <= addr_in[BEAT_W-1:0];
      order_q  <= order_in;
      active_q <= 1'b1;
    end
  end

  assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(upper_q) && $stable(start_q));
  assert_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(order_q));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q && {upper_q, start_q} == $past(addr_in));
endmodule

// File: rtl/bseq_lane_map.sv
module bseq_lane_map #(
  parameter int BEAT_W = 2
) (
  input  logic              order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lane
);
  import burst_seq_pkg::*;

  logic [BEAT_W-1:0] lin_lane;
  logic [BEAT_W-1:0] ilv_lane;

  always_comb begin
    lin_lane = start + beat;
    ilv_lane = start ^ beat;
    lane = (order == ORDER_INTERLEAVE) ? ilv_lane : lin_lane;
  end

  // Beat zero always presents the starting offset, whatever the order.
  always_comb begin
    if (!$isunknown({start, beat}) && beat == '0)
      assert_first_beat_R2: assert (lane == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_out,
  output logic              burst_active
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic              active_q;
  logic              order_q;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] lane;

  bseq_load_ctrl u_ctrl (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .active       (active_q),
    .load         (load),
    .step         (step)
  );

  bseq_addr_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .addr_in  (addr_in),
    .order_in (order_sel),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .order_q  (order_q),
    .active_q (active_q)
  );

  bseq_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .cnt   (cnt)
  );

  bseq_lane_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order_q),
    .start (start_q),
    .beat  (cnt),
    .lane  (lane)
  );

  assign addr_out     = {upper_q, lane};
  assign beat_out     = cnt;
  assign burst_active = active_q;

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load) |=> (!burst_active && beat_out == '0));
  assert_upper_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_cpu_n = 1'b1;
  logic          strobe_ctl_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .order_sel(order_sel),
    .addr_out(addr_out), .beat_out(beat_out), .burst_active(burst_active)
  );

  function automatic logic [1:0] ref_lane(logic [1:0] s, logic [1:0] k, logic m);
    return m ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic chk(string req, logic [AW+2:0] act, logic [AW+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_load(logic [AW-1:0] a, logic m, logic cpu, logic ctl);
    @(negedge clk);
    addr_in = a; order_sel = m;
    strobe_cpu_n = ~cpu; strobe_ctl_n = ~ctl;
    tick();
    @(negedge clk);
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1", {addr_out, beat_out, burst_active}, '0);
  endtask

  task automatic t_idle_advance;
    @(negedge clk); advance_n = 1'b0;
    repeat (3) tick();
    chk("R10", {beat_out, burst_active}, '0);
    @(negedge clk); advance_n = 1'b1;
  endtask

  task automatic t_burst(logic [AW-1:0] a, logic m, logic use_cpu);
    string rq;
    rq = m ? "R5" : "R4";
    do_load(a, m, use_cpu, ~use_cpu);
    chk("R2", {addr_out, beat_out, burst_active}, {a, 2'd0, 1'b1});
    advance_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(rq, {addr_out[1:0], beat_out}, {ref_lane(a[1:0], 2'(k), m), 2'(k)});
      chk("R6", addr_out[AW-1:2], a[AW-1:2]);
    end
    chk("R7", beat_out, 2'd2);
    @(negedge clk); advance_n = 1'b1;
    repeat (2) tick();
    chk("R3", {addr_out[1:0], beat_out}, {ref_lane(a[1:0], 2'd2, m), 2'd2});
  endtask

  task automatic t_priority;
    do_load(16'h1230, 1'b0, 1'b1, 1'b0);
    advance_n = 1'b0;
    tick();
    @(negedge clk);
    addr_in = 16'hBEE2; order_sel = 1'b1; strobe_ctl_n = 1'b0;
    tick();
    chk("R8", {addr_out, beat_out}, {16'hBEE2, 2'd0});
    @(negedge clk); strobe_ctl_n = 1'b1;
    tick();
    chk("R8", {addr_out, beat_out}, {16'hBEE3, 2'd1});
    @(negedge clk); advance_n = 1'b1;
  endtask

  task automatic t_mode_change;
    do_load(16'h4441, 1'b0, 1'b1, 1'b0);
    order_sel = 1'b1; advance_n = 1'b0;
    tick();
    chk("R9", addr_out, 16'h4442);
    tick();
    chk("R9", addr_out, 16'h4443);
    @(negedge clk); advance_n = 1'b1;
  endtask

  task automatic t_both;
    do_load(16'h0F0E, 1'b1, 1'b1, 1'b1);
    chk("R11", {addr_out, beat_out, burst_active}, {16'h0F0E, 2'd0, 1'b1});
    advance_n = 1'b0;
    tick();
    chk("R11", addr_out, 16'h0F0F);
    @(negedge clk); advance_n = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick();
    t_reset();
    t_idle_advance();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_burst(16'hA5C0 + 16'(s) + 16'(m * 16'h0110), m[0], s[0]);
    t_priority();
    t_mode_change();
    t_both();
    finish_run();
  end

  initial begin
    #(4 * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule